// File: doc/BRIEF.md
# Reset Source Controller and Recorder

This block collects reset requests from six places and decides for each one whether it becomes a full system reset or a reset of the core digital domain only. Two of the sources always lead to a system reset: a clock-loss flag from an external detector and a software system-reset write. Three processor-side sources are warm: a processor reset request, a processor lockup and a watchdog timeout. A software core-reset write also resets the core domain.

A system reset is issued as a one-cycle pulse. In the same cycle the block's own configuration and warm status are cleared and a source code is stored that stays readable once the chip has recovered. A core-domain reset runs a fixed-length sequence with a counter. It leaves the clock-loss enables and the stored source code alone. Software can set a conversion bit so that every warm source becomes a full system reset instead.

Clock loss only acts when two separate enables are both set. The two enables sit in two different configuration groups, one on the oscillator side and one on the system side. Both enables read zero after power-up.

Top module: `rst_source_ctrl`

## Requirements
- R1: With both clock-loss enables set, a high `clk_loss_i` makes `sys_rst_o` high in the next cycle, and `rst_src_o` then reads 1 (clock loss).
- R2: After power-on reset, both clock-loss enables, the conversion bit and both warm status bits read 0, and `rst_src_o` reads 0 (power-on). While either enable is clear, `clk_loss_i` has no effect.
- R3: A high `sw_sysrst_wr_i` gives a `sys_rst_o` pulse in the next cycle, with `rst_src_o` = 2 (software system reset).
- R4: `sys_rst_o` is high for one cycle per request. In that cycle both enables, the conversion bit and both warm status bits read 0, and `rst_src_o` holds the new code.
- R5: A warm source with the conversion bit clear starts the core-domain sequence. It raises no `sys_rst_o` and leaves `rst_src_o` and both clock-loss enables unchanged.
- R6: On a warm reset, `warm_lockup_o` is set only for a lockup cause and `warm_wdog_o` only for a watchdog cause. A processor request clears both bits.
- R7: With the conversion bit set, any warm source gives a `sys_rst_o` pulse instead of the sequence, and `rst_src_o` = 3 (converted warm reset).
- R8: `core_rst_o` rises in the cycle after the accepted request and stays high for exactly CORE_RST_CYCLES cycles (default 8). In the cycle after the last one, `core_rst_o` is low and `core_done_o` is high for one cycle.
- R9: `sw_core_rst_wr_i` starts the same sequence and clears the conversion bit and both warm status bits. It keeps both clock-loss enables and `rst_src_o`.
- R10: When several requests arrive in the same cycle, only the highest one acts and is recorded. The order, highest first, is: armed clock loss, software system reset, lockup, watchdog, processor request, software core reset.
- R11: While `core_rst_o` is high, warm sources (with the conversion bit clear) and `sw_core_rst_wr_i` are ignored. A system reset in that time ends the sequence, so `core_rst_o` is low in the pulse cycle.
- R12: `osc_cfg_wr_i` loads `osc_loss_en_o` from `osc_loss_en_i`. `sys_cfg_wr_i` loads `sys_loss_en_o` and `warm_conv_o` from their inputs. A system reset or core-reset clear in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| clk_loss_i | input | 1 | Clock-loss flag from external detector |
| sw_sysrst_wr_i | input | 1 | Software system-reset write strobe |
| cpu_rst_req_i | input | 1 | Processor reset request |
| cpu_lockup_i | input | 1 | Processor lockup |
| wdog_timeout_i | input | 1 | Watchdog timeout |
| sw_core_rst_wr_i | input | 1 | Software core-domain reset write strobe |
| osc_cfg_wr_i | input | 1 | Write strobe, oscillator-side enable |
| osc_loss_en_i | input | 1 | Write data, oscillator-side clock-loss enable |
| sys_cfg_wr_i | input | 1 | Write strobe, system-side configuration |
| sys_loss_en_i | input | 1 | Write data, system-side clock-loss enable |
| warm_conv_i | input | 1 | Write data, warm-to-system conversion bit |
| sys_rst_o | output | 1 | System reset pulse |
| core_rst_o | output | 1 | Core-domain reset |
| core_done_o | output | 1 | One-cycle flag when the core sequence ends |
| rst_src_o | output | 2 | Last system reset source: 0 power-on, 1 clock loss, 2 software, 3 converted warm |
| warm_lockup_o | output | 1 | Last warm reset was a lockup |
| warm_wdog_o | output | 1 | Last warm reset was a watchdog timeout |
| osc_loss_en_o | output | 1 | Oscillator-side clock-loss enable |
| sys_loss_en_o | output | 1 | System-side clock-loss enable |
| warm_conv_o | output | 1 | Warm-to-system conversion bit |

## Verification
The hardest cases to reach from the ports are requests that land while the core sequence is running. A dropped warm request is only visible because nothing changes afterwards. A system reset that cuts the sequence short has to arrive partway through the count. The stimulus starts a sequence, then waits a chosen number of cycles before applying each such request. A cycle-accurate reference model tracks the counter, so every one of these cases is compared on every clock. The priority cases drive several sources in the same cycle, after first setting up the enables and the conversion bit so that each level of the order is the deciding one.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        SRC_POR       = 2'd0,
        SRC_CLK_LOSS  = 2'd1,
        SRC_SW_SYS    = 2'd2,
        SRC_WARM_CONV = 2'd3
    } rst_src_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_CLK_LOSS,
        EV_SW_SYS,
        EV_LOCKUP,
        EV_WDOG,
        EV_CPU_REQ,
        EV_SW_CORE
    } rst_event_e;

endpackage

// File: rtl/rsc_arbiter.sv
module rsc_arbiter
    import rsc_pkg::*;
(
    input  logic       loss_armed_i,
    input  logic       clk_loss_i,
    input  logic       sw_sys_i,
    input  logic       lockup_i,
    input  logic       wdog_i,
    input  logic       cpu_req_i,
    input  logic       sw_core_i,
    input  logic       warm_conv_i,
    input  logic       busy_i,
    output rst_event_e event_o,
    output logic       is_sys_o,
    output rst_src_e   sys_code_o
);
    logic warm_any;
    assign warm_any = lockup_i | wdog_i | cpu_req_i;

    always_comb begin
        event_o    = EV_NONE;
        is_sys_o   = 1'b0;
        sys_code_o = SRC_POR;
        if (loss_armed_i && clk_loss_i) begin
            event_o    = EV_CLK_LOSS;
            is_sys_o   = 1'b1;
            sys_code_o = SRC_CLK_LOSS;
        end else if (sw_sys_i) begin
            event_o    = EV_SW_SYS;
            is_sys_o   = 1'b1;
            sys_code_o = SRC_SW_SYS;
        end else if (warm_any && warm_conv_i) begin
            event_o    = lockup_i ? EV_LOCKUP : (wdog_i ? EV_WDOG : EV_CPU_REQ);
            is_sys_o   = 1'b1;
            sys_code_o = SRC_WARM_CONV;
        end else if (!busy_i) begin
            if (lockup_i)        event_o = EV_LOCKUP;
            else if (wdog_i)     event_o = EV_WDOG;
            else if (cpu_req_i)  event_o = EV_CPU_REQ;
            else if (sw_core_i)  event_o = EV_SW_CORE;
        end
    end
endmodule

// File: rtl/rsc_core_seq.sv
module rsc_core_seq #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic start_i,
    input  logic abort_i,
    output logic core_rst_o,
    output logic done_o
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort_i) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
        end else if (s_q.active) begin
            if (s_q.cnt == LAST) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_rst_o = s_q.active;
    assign done_o     = s_q.done;
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rsc_pkg::*;
#(
    parameter int CORE_RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       clk_loss_i,
    input  logic       sw_sysrst_wr_i,
    input  logic       cpu_rst_req_i,
    input  logic       cpu_lockup_i,
    input  logic       wdog_timeout_i,
    input  logic       sw_core_rst_wr_i,
    input  logic       osc_cfg_wr_i,
    input  logic       osc_loss_en_i,
    input  logic       sys_cfg_wr_i,
    input  logic       sys_loss_en_i,
    input  logic       warm_conv_i,
    output logic       sys_rst_o,
    output logic       core_rst_o,
    output logic       core_done_o,
    output logic [1:0] rst_src_o,
    output logic       warm_lockup_o,
    output logic       warm_wdog_o,
    output logic       osc_loss_en_o,
    output logic       sys_loss_en_o,
    output logic       warm_conv_o
);
    typedef struct packed {
        logic     osc_en;
        logic     sys_en;
        logic     conv;
        logic     st_lockup;
        logic     st_wdog;
        logic     sys_pulse;
        rst_src_e src;
    } ctl_t;

    ctl_t       c_d, c_q;
    rst_event_e ev;
    logic       ev_sys;
    rst_src_e   ev_code;
    logic       seq_start;

    rsc_arbiter u_arb (
        .loss_armed_i (c_q.osc_en & c_q.sys_en),
        .clk_loss_i   (clk_loss_i),
        .sw_sys_i     (sw_sysrst_wr_i),
        .lockup_i     (cpu_lockup_i),
        .wdog_i       (wdog_timeout_i),
        .cpu_req_i    (cpu_rst_req_i),
        .sw_core_i    (sw_core_rst_wr_i),
        .warm_conv_i  (c_q.conv),
        .busy_i       (core_rst_o),
        .event_o      (ev),
        .is_sys_o     (ev_sys),
        .sys_code_o   (ev_code)
    );

    always_comb begin
        c_d           = c_q;
        c_d.sys_pulse = 1'b0;
        seq_start     = 1'b0;
        if (osc_cfg_wr_i) c_d.osc_en = osc_loss_en_i;
        if (sys_cfg_wr_i) begin
            c_d.sys_en = sys_loss_en_i;
            c_d.conv   = warm_conv_i;
        end
        if (ev_sys) begin
            c_d.osc_en    = 1'b0;
            c_d.sys_en    = 1'b0;
            c_d.conv      = 1'b0;
            c_d.st_lockup = 1'b0;
            c_d.st_wdog   = 1'b0;
            c_d.sys_pulse = 1'b1;
            c_d.src       = ev_code;
        end else begin
            case (ev)
                EV_LOCKUP, EV_WDOG, EV_CPU_REQ: begin
                    c_d.st_lockup = (ev == EV_LOCKUP);
                    c_d.st_wdog   = (ev == EV_WDOG);
                    seq_start     = 1'b1;
                end
                EV_SW_CORE: begin
                    c_d.conv      = 1'b0;
                    c_d.st_lockup = 1'b0;
                    c_d.st_wdog   = 1'b0;
                    seq_start     = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            c_q     <= '0;
            c_q.src <= SRC_POR;
        end else begin
            c_q <= c_d;
        end
    end

    rsc_core_seq #(.CYCLES(CORE_RST_CYCLES)) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .start_i    (seq_start),
        .abort_i    (ev_sys),
        .core_rst_o (core_rst_o),
        .done_o     (core_done_o)
    );

    assign sys_rst_o     = c_q.sys_pulse;
    assign rst_src_o     = c_q.src;
    assign warm_lockup_o = c_q.st_lockup;
    assign warm_wdog_o   = c_q.st_wdog;
    assign osc_loss_en_o = c_q.osc_en;
    assign sys_loss_en_o = c_q.sys_en;
    assign warm_conv_o   = c_q.conv;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int CORE_RST_CYCLES = 8
) (
    input logic       clk,
    input logic       por_n,
    input logic       clk_loss_i,
    input logic       sw_sysrst_wr_i,
    input logic       cpu_rst_req_i,
    input logic       cpu_lockup_i,
    input logic       wdog_timeout_i,
    input logic       sys_rst_o,
    input logic       core_rst_o,
    input logic       core_done_o,
    input logic [1:0] rst_src_o,
    input logic       warm_lockup_o,
    input logic       warm_wdog_o,
    input logic       osc_loss_en_o,
    input logic       sys_loss_en_o,
    input logic       warm_conv_o
);
    localparam int HW = $clog2(CORE_RST_CYCLES + 2) + 1;
    logic [HW-1:0] hi_cnt;
    logic          warm_any;
    assign warm_any = cpu_lockup_i | wdog_timeout_i | cpu_rst_req_i;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          hi_cnt <= '0;
        else if (core_rst_o) hi_cnt <= hi_cnt + 1'b1;
        else                 hi_cnt <= '0;
    end

    assert_loss_armed_R1: assert property (@(posedge clk) disable iff (!por_n)
        (clk_loss_i && osc_loss_en_o && sys_loss_en_o) |=> (sys_rst_o && rst_src_o == 2'd1));

    assert_loss_gated_R2: assert property (@(posedge clk) disable iff (!por_n)
        (clk_loss_i && !(osc_loss_en_o && sys_loss_en_o) && !sw_sysrst_wr_i
         && !(warm_conv_o && warm_any)) |=> !sys_rst_o);

    assert_sw_sys_R3: assert property (@(posedge clk) disable iff (!por_n)
        sw_sysrst_wr_i |=> (sys_rst_o && (rst_src_o == 2'd1 || rst_src_o == 2'd2)));

    assert_cleared_on_pulse_R4: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_o |-> (!osc_loss_en_o && !sys_loss_en_o && !warm_conv_o
                       && !warm_lockup_o && !warm_wdog_o));

    assert_status_excl_R6: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({warm_lockup_o, warm_wdog_o}));

    assert_warm_conv_R7: assert property (@(posedge clk) disable iff (!por_n)
        (warm_conv_o && warm_any && !clk_loss_i && !sw_sysrst_wr_i) |=>
        (sys_rst_o && rst_src_o == 2'd3));

    assert_seq_len_R8: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(core_rst_o) && !sys_rst_o) |-> (core_done_o && hi_cnt == HW'(CORE_RST_CYCLES)));

    assert_abort_R11: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_o |-> !core_rst_o);
endmodule

bind rst_source_ctrl rsc_checker #(.CORE_RST_CYCLES(CORE_RST_CYCLES)) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .clk_loss_i     (clk_loss_i),
    .sw_sysrst_wr_i (sw_sysrst_wr_i),
    .cpu_rst_req_i  (cpu_rst_req_i),
    .cpu_lockup_i   (cpu_lockup_i),
    .wdog_timeout_i (wdog_timeout_i),
    .sys_rst_o      (sys_rst_o),
    .core_rst_o     (core_rst_o),
    .core_done_o    (core_done_o),
    .rst_src_o      (rst_src_o),
    .warm_lockup_o  (warm_lockup_o),
    .warm_wdog_o    (warm_wdog_o),
    .osc_loss_en_o  (osc_loss_en_o),
    .sys_loss_en_o  (sys_loss_en_o),
    .warm_conv_o    (warm_conv_o)
);

// File: tb/rst_source_ctrl_bench.sv
`timescale 1ns/1ps
module rst_source_ctrl_bench;
    localparam int N = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic clk_loss, sw_sys, cpu_req, lockup, wdog, sw_core;
    logic osc_wr, osc_en_in, sys_wr, sys_en_in, conv_in;
    logic sys_rst, core_rst, core_done, st_lk, st_wd, osc_en, sys_en, conv;
    logic [1:0] src;

    always #2.5 clk = ~clk;

    rst_source_ctrl #(.CORE_RST_CYCLES(N)) u_rst_source_ctrl (
        .clk(clk), .por_n(por_n), .clk_loss_i(clk_loss), .sw_sysrst_wr_i(sw_sys),
        .cpu_rst_req_i(cpu_req), .cpu_lockup_i(lockup), .wdog_timeout_i(wdog),
        .sw_core_rst_wr_i(sw_core), .osc_cfg_wr_i(osc_wr), .osc_loss_en_i(osc_en_in),
        .sys_cfg_wr_i(sys_wr), .sys_loss_en_i(sys_en_in), .warm_conv_i(conv_in),
        .sys_rst_o(sys_rst), .core_rst_o(core_rst), .core_done_o(core_done),
        .rst_src_o(src), .warm_lockup_o(st_lk), .warm_wdog_o(st_wd),
        .osc_loss_en_o(osc_en), .sys_loss_en_o(sys_en), .warm_conv_o(conv)
    );

    int vectors = 0;
    int errors  = 0;

    // reference model state
    bit m_osc, m_sys, m_conv, m_lk, m_wd, m_pulse, m_crst, m_done;
    int m_src, m_cnt;

    task automatic clear_in();
        clk_loss = 0; sw_sys = 0; cpu_req = 0; lockup = 0; wdog = 0; sw_core = 0;
        osc_wr = 0; osc_en_in = 0; sys_wr = 0; sys_en_in = 0; conv_in = 0;
    endtask

    task automatic model_edge();
        bit busy;
        int code;
        busy = m_crst;
        code = 0;
        if (clk_loss && m_osc && m_sys)                  code = 1;
        else if (sw_sys)                                 code = 2;
        else if (m_conv && (lockup || wdog || cpu_req))  code = 3;
        m_pulse = 0;
        m_done  = 0;
        if (m_crst) begin
            if (m_cnt == N) begin m_crst = 0; m_done = 1; end
            else m_cnt++;
        end
        if (osc_wr) m_osc = osc_en_in;
        if (sys_wr) begin m_sys = sys_en_in; m_conv = conv_in; end
        if (code != 0) begin
            m_osc = 0; m_sys = 0; m_conv = 0; m_lk = 0; m_wd = 0;
            m_src = code; m_pulse = 1; m_crst = 0; m_done = 0; m_cnt = 0;
        end else if (!busy) begin
            if (lockup || wdog || cpu_req) begin
                m_lk = lockup;
                m_wd = !lockup && wdog;
                m_crst = 1; m_cnt = 1;
            end else if (sw_core) begin
                m_conv = 0; m_lk = 0; m_wd = 0;
                m_crst = 1; m_cnt = 1;
            end
        end
    endtask

    task automatic compare(input string req);
        logic [10:0] got, exp;
        got = {sys_rst, core_rst, core_done, src, st_lk, st_wd, osc_en, sys_en, conv, 1'b0};
        exp = {m_pulse, m_crst, m_done, 2'(m_src), m_lk, m_wd, m_osc, m_sys, m_conv, 1'b0};
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%b expected=%b (pulse,core,done,src[2],lk,wd,osc,sys,conv,-)",
                     req, $time, got, exp);
        end
    endtask

    // drive inputs (already set at a falling edge), clock once, compare, clear
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
        clear_in();
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic set_cfg(input bit o, input bit s, input bit c);
        osc_wr = 1; osc_en_in = o; sys_wr = 1; sys_en_in = s; conv_in = c;
        step("R12");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        clear_in();
        m_src = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        compare("R2 reset state");

        // R2: clock loss with enables clear, then with only one enable
        clk_loss = 1; step("R2");
        idle(1, "R2");
        osc_wr = 1; osc_en_in = 1; step("R12");
        clk_loss = 1; step("R2 one enable");
        idle(1, "R2");

        // R1 / R4: armed clock loss
        set_cfg(1, 1, 0);
        clk_loss = 1; step("R1");
        idle(1, "R4 pulse ends");

        // R3 with a concurrent cfg write: reset wins (R12)
        sw_sys = 1; osc_wr = 1; osc_en_in = 1; step("R3");
        idle(1, "R4");

        // R5, R6, R8: lockup warm reset with enables set first
        set_cfg(1, 1, 0);
        lockup = 1; step("R5 lockup");
        idle(3, "R8");
        // R11: requests during sequence are ignored
        wdog = 1; step("R11 wdog busy");
        sw_core = 1; step("R11 core busy");
        idle(N, "R8 release and done");

        wdog = 1; step("R6 wdog");
        idle(N + 1, "R8");
        cpu_req = 1; step("R6 cpu req");
        idle(N + 1, "R8");

        // R9: software core reset clears conv and status, keeps enables/src
        lockup = 1; step("R6");
        idle(N + 1, "R8");
        sys_wr = 1; sys_en_in = 1; conv_in = 1; step("R12");
        sw_core = 1; step("R9");
        idle(N + 1, "R9");

        // R7: conversion of each warm source
        set_cfg(1, 1, 1);
        wdog = 1; step("R7 wdog");
        idle(1, "R7");
        set_cfg(0, 0, 1);
        cpu_req = 1; step("R7 cpu req");
        idle(1, "R7");

        // R10: priority checks
        set_cfg(1, 1, 1);
        clk_loss = 1; sw_sys = 1; lockup = 1; step("R10 loss over sw");
        sw_sys = 1; lockup = 1; step("R10 sw over warm");
        idle(1, "R10");
        lockup = 1; wdog = 1; cpu_req = 1; sw_core = 1; step("R10 lockup first");
        idle(N + 1, "R10");
        wdog = 1; cpu_req = 1; step("R10 wdog over req");
        idle(N + 1, "R10");
        sys_wr = 1; sys_en_in = 0; conv_in = 1; step("R12");
        cpu_req = 1; sw_core = 1; step("R10 req over core");
        idle(N + 1, "R10");

        // R11: system reset aborts a running sequence
        sys_wr = 1; sys_en_in = 0; conv_in = 0; step("R12");
        sw_core = 1; step("R9");
        idle(4, "R8");
        sw_sys = 1; step("R11 abort");
        idle(3, "R11");

        // R12: cfg write ignored when core reset clears conv in the same cycle
        sys_wr = 1; sys_en_in = 1; conv_in = 1; sw_core = 1; step("R12 clear wins");
        idle(N + 1, "R12");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule